// File: doc/BRIEF.md
# Tamper-Protected Backup Register Controller

This block keeps a small bank of backup data words behind a register bus and protects them against tampering. A one-cycle tamper strobe from an external detector marks an event. The event wipes every data word to zero. While the event stays latched, the words are held at zero and bus writes to them are dropped. Software must acknowledge the event through a control/status word before the bank becomes usable again.

The control/status word holds three state bits: a latched event flag, an interrupt flag and an interrupt enable. It also holds two command bits. Writing 1 to a command bit clears the matching flag; writing 0 to it does nothing. The interrupt flag drives a registered interrupt output. The interrupt flag is raised only when the interrupt enable is set and the separate tamper-pin enable input is high. Reads are combinational: the read data always shows the word selected by the current address.

Top module: `tamper_bkp_ctrl`

## Requirements
- R1: After reset, the control/status word (address 10) reads 0x0000, every data word reads 0x0000 and `irq_o` is 0.
- R2: The control/status word has this layout. Bit 9 is the interrupt flag (read-only). Bit 8 is the event flag (read-only). Bit 2 is the interrupt enable (read/write). Bits 1 and 0 are write-one commands that always read as 0. All other bits read as 0, so writing 0xFFFF with no event pending reads back 0x0004.
- R3: A cycle with `tamper_i` high sets the event flag, which is visible from the next cycle.
- R4: The event flag is cleared only by a control/status write with bit 0 set. A write with bit 0 clear leaves the flag unchanged.
- R5: The interrupt flag is set by a tamper cycle only when the interrupt enable is 1 and `pin_en_i` is 1. With `pin_en_i` low, the interrupt flag and `irq_o` stay 0.
- R6: A control/status write with bit 1 set clears the interrupt flag, and `irq_o` falls one cycle later.
- R7: Writing the interrupt enable to 0 clears the interrupt flag in the same cycle.
- R8: `irq_o` equals the interrupt flag delayed by one clock.
- R9: A tamper cycle sets every data word to 0x0000 from the next cycle.
- R10: While the event flag is set, data words stay 0x0000 and writes to them are discarded. After the flag is cleared, writes take effect again.
- R11: If a tamper cycle and a clear command for the same flag arrive in the same cycle, the flag ends up set.
- R12: Data words sit at word addresses 0 to 9, and each reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tamper_i | input | 1 | One-cycle tamper detect strobe, synchronous to clk |
| pin_en_i | input | 1 | Tamper-pin enable; required for the interrupt |
| bus_addr_i | input | 4 | Word address (0-9 data, 10 control/status) |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Registered tamper interrupt |

## Verification
The assertions assume that `tamper_i`, `pin_en_i` and the bus inputs are synchronous to `clk` and stable around the rising edge. They also assume that a bus write lasts exactly one cycle and targets one word. The stimulus changes every input only on the falling edge and drops the write strobe after one cycle. Tamper strobes are also single-cycle. The one case where a tamper strobe and a clear command share a cycle is issued on purpose, to exercise the set-over-clear priority.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
  localparam int unsigned CSR_W       = 16;
  localparam int unsigned BIT_CLR_EVT = 0;
  localparam int unsigned BIT_CLR_INT = 1;
  localparam int unsigned BIT_INT_EN  = 2;
  localparam int unsigned BIT_EVT     = 8;
  localparam int unsigned BIT_INT     = 9;

  typedef struct packed {
    logic int_flag;
    logic evt_flag;
    logic int_en;
  } tbk_state_t;
endpackage

// File: rtl/tbk_rst_sync.sv
module tbk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tbk_flags.sv
module tbk_flags
  import tbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tamper_i,
  input  logic             pin_en_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output tbk_state_t       state_o,
  output logic             irq_o
);
  tbk_state_t st_q, st_d;
  logic       irq_q;
  logic       clr_evt, clr_int, en_nxt, set_int;

  always_comb begin
    clr_evt = csr_we_i && csr_wdata_i[BIT_CLR_EVT];
    clr_int = csr_we_i && csr_wdata_i[BIT_CLR_INT];
    en_nxt  = csr_we_i ? csr_wdata_i[BIT_INT_EN] : st_q.int_en;
    set_int = tamper_i && st_q.int_en && pin_en_i;

    st_d        = st_q;
    st_d.int_en = en_nxt;
    // set wins over clear (R11)
    if (tamper_i)                st_d.evt_flag = 1'b1;
    else if (clr_evt)            st_d.evt_flag = 1'b0;
    if (set_int)                 st_d.int_flag = 1'b1;
    else if (clr_int || !en_nxt) st_d.int_flag = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= st_q.int_flag;
    end
  end

  assign state_o = st_q;
  assign irq_o   = irq_q;

  a_r3_evt_set: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_i |=> st_q.evt_flag);
  a_r4_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.evt_flag && !(csr_we_i && csr_wdata_i[BIT_CLR_EVT])) |=> st_q.evt_flag);
  a_r5_int_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q.int_flag && tamper_i && !pin_en_i) |=> !st_q.int_flag);
  a_r5_int_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_i && pin_en_i && st_q.int_en) |=> st_q.int_flag);
  a_r6_int_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_wdata_i[BIT_CLR_INT] && !tamper_i) |=> !st_q.int_flag);
  a_r7_en_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q.int_en && !(csr_we_i && csr_wdata_i[BIT_INT_EN])) |=> !st_q.int_flag);
  a_r8_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.int_flag) |=> irq_o);
endmodule

// File: rtl/tbk_bank.sv
module tbk_bank #(
  parameter int unsigned NUM_REGS = 10,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             hold_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  store_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] store_q, store_d;
  logic [NUM_REGS-1:0]             sel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    assign sel[i] = we_i && (addr_i == ADDR_W'(i));

    always_comb begin
      if (hold_i)      store_d[i] = '0;
      else if (sel[i]) store_d[i] = wdata_i;
      else             store_d[i] = store_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store_q[i] <= '0;
      else        store_q[i] <= store_d[i];
    end
  end

  assign store_o = store_q;

  a_r9_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (store_q == '0));
  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !hold_i && (addr_i < ADDR_W'(NUM_REGS)))
      |=> (store_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tamper_bkp_ctrl.sv
module tamper_bkp_ctrl
  import tbk_pkg::*;
#(
  parameter int unsigned NUM_REGS = 10,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tamper_i,
  input  logic              pin_en_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [CSR_W-1:0]  bus_wdata_i,
  output logic [CSR_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] CSR_ADDR = ADDR_W'(NUM_REGS);

  logic                           rst_q_n;
  logic                           csr_hit, csr_we;
  tbk_state_t                     st;
  logic [NUM_REGS-1:0][CSR_W-1:0] store;
  logic [CSR_W-1:0]               csr_rd;

  tbk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign csr_hit = (bus_addr_i == CSR_ADDR);
  assign csr_we  = bus_we_i && csr_hit;

  tbk_flags u_flags (
    .clk(clk), .rst_n(rst_q_n), .tamper_i(tamper_i), .pin_en_i(pin_en_i),
    .csr_we_i(csr_we), .csr_wdata_i(bus_wdata_i), .state_o(st), .irq_o(irq_o)
  );

  tbk_bank #(.NUM_REGS(NUM_REGS), .DATA_W(CSR_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .hold_i(tamper_i || st.evt_flag),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .store_o(store)
  );

  always_comb begin
    csr_rd              = '0;
    csr_rd[BIT_INT]     = st.int_flag;
    csr_rd[BIT_EVT]     = st.evt_flag;
    csr_rd[BIT_INT_EN]  = st.int_en;
    if (csr_hit)                       bus_rdata_o = csr_rd;
    else if (bus_addr_i < CSR_ADDR)    bus_rdata_o = store[bus_addr_i];
    else                               bus_rdata_o = '0;
  end

  a_r10_held_reads_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st.evt_flag && (bus_addr_i < CSR_ADDR)) |-> (bus_rdata_o == '0));
  a_r1_irq_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(irq_o) |-> $past(st.int_flag));
endmodule

// File: tb/tamper_bkp_ctrl_test.sv
`timescale 1ns/1ps
module tamper_bkp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tamper_i, pin_en_i, bus_we_i;
  logic [3:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic [15:0] bus_rdata_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  tamper_bkp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tamper_i(tamper_i), .pin_en_i(pin_en_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  task automatic pulse_tamper();
    @(negedge clk);
    tamper_i = 1'b1;
    @(negedge clk);
    tamper_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(4'd10, v); chk("R1 csr", v, 16'h0000);
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v); chk("R1 data", v, 16'h0000);
    end
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);
  endtask

  task automatic t_rw();
    logic [15:0] v;
    for (int i = 0; i < 10; i++) wr(4'(i), 16'hA000 + 16'(i * 17));
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v); chk("R12 readback", v, 16'hA000 + 16'(i * 17));
    end
    wr(4'd10, 16'hFFFF); rd(4'd10, v); chk("R2 layout", v, 16'h0004);
    wr(4'd10, 16'h0000); rd(4'd10, v); chk("R2 en off", v, 16'h0000);
  endtask

  task automatic t_event();
    logic [15:0] v;
    pulse_tamper();
    rd(4'd10, v); chk("R3 evt set", v, 16'h0100);
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v); chk("R9 wiped", v, 16'h0000);
    end
    chk("R5 no irq when disabled", {15'd0, irq_o}, 16'h0000);
    wr(4'd3, 16'h5A5A); rd(4'd3, v); chk("R10 write dropped", v, 16'h0000);
    wr(4'd10, 16'h0000); rd(4'd10, v); chk("R4 zero no effect", v, 16'h0100);
    wr(4'd10, 16'h0001); rd(4'd10, v); chk("R4 cleared", v, 16'h0000);
    wr(4'd3, 16'h1234); rd(4'd3, v); chk("R10 write after clear", v, 16'h1234);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    pin_en_i = 1'b1;
    wr(4'd10, 16'h0004);
    pulse_tamper();
    rd(4'd10, v); chk("R5 int set", v, 16'h0304);
    chk("R8 irq lags", {15'd0, irq_o}, 16'h0000);
    @(negedge clk);
    chk("R8 irq up", {15'd0, irq_o}, 16'h0001);
    wr(4'd10, 16'h0006);
    rd(4'd10, v); chk("R6 int cleared", v, 16'h0104);
    chk("R6 irq still up one cycle", {15'd0, irq_o}, 16'h0001);
    @(negedge clk);
    chk("R6 irq down", {15'd0, irq_o}, 16'h0000);
    wr(4'd10, 16'h0005); rd(4'd10, v); chk("R4 clear keeps en", v, 16'h0004);
  endtask

  task automatic t_pin_off();
    logic [15:0] v;
    pin_en_i = 1'b0;
    pulse_tamper();
    rd(4'd10, v); chk("R5 pin off no int", v, 16'h0104);
    @(negedge clk);
    chk("R5 pin off irq", {15'd0, irq_o}, 16'h0000);
    wr(4'd10, 16'h0005);
    pin_en_i = 1'b1;
  endtask

  task automatic t_en_off();
    logic [15:0] v;
    pulse_tamper();
    rd(4'd10, v); chk("R7 pre", v, 16'h0304);
    wr(4'd10, 16'h0000); rd(4'd10, v); chk("R7 en off clears int", v, 16'h0100);
    wr(4'd10, 16'h0005);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    @(negedge clk);
    tamper_i = 1'b1; bus_addr_i = 4'd10; bus_wdata_i = 16'h0007; bus_we_i = 1'b1;
    @(negedge clk);
    tamper_i = 1'b0; bus_we_i = 1'b0;
    rd(4'd10, v); chk("R11 set beats clear", v, 16'h0304);
    wr(4'd10, 16'h0003); rd(4'd10, v); chk("R11 later clear", v, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; tamper_i = 1'b0; pin_en_i = 1'b0; bus_we_i = 1'b0;
    bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_event();
    t_irq();
    t_pin_off();
    t_en_off();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule